// File: doc/BRIEF.md
# Power-Stage Fault Supervisor

This block sequences a switching LED controller through start-up, normal switching and fault recovery. It takes digital supply-level flags, protection flags and the valley comparator level, and it decides whether the power switch may be driven. It also decides whether the start-up current source should charge the supply, and it reports a 3-bit state code.

Faults fall into three classes, and each class recovers in its own way. Hiccup-class faults (brown-out, over-temperature, shorted current sense) park the block until the supply decays to its turn-off level. Recovery-class faults (supply over-voltage, winding or diode short, output or auxiliary short) wait out a fixed recovery interval. The latched variant is chosen by a parameter. In that variant a winding short or an auxiliary short freezes the block until the supply collapses below its logic-reset level. The length of every interval is a parameter in clock cycles.

Top module: `fault_supervisor`

## Requirements
- R1: After reset the state code is 0 (idle), drive enable is low and start-up current select is high.
- R2: From idle the block moves to stopped (code 1) one cycle after the turn-on flag is high, and it stays idle while that flag is low.
- R3: The stopped state lasts exactly SOFTSTART_CYCLES cycles, with drive enable low, and then the block enters running (code 2). Drive enable is high only in running.
- R4: In idle, stopped, running or discharge, a high turn-off flag returns the block to idle on the next cycle.
- R5: In stopped or running, brown-out, over-temperature or current-sense short moves the block to discharge (code 3). It stays there until the turn-off flag rises.
- R6: A 1-to-0 transition of the brown-out flag in discharge (or idle, stopped, running) returns the block to idle at once, without waiting for the turn-off flag.
- R7: In running, supply over-voltage, a winding short or an auxiliary short moves the block to recovery (code 4). Recovery lasts exactly RECOVERY_CYCLES cycles and then returns to idle. The turn-off and brown-out flags have no effect during recovery.
- R8: With LATCHED=1, a winding short or an auxiliary short in running moves the block to latched (code 5). Latched ignores the turn-off flag, brown-out and all faults, and it leaves only on the reset-level flag.
- R9: With LATCHED=1, supply over-voltage still leads to recovery, not to latched.
- R10: An auxiliary short is declared when the valley-low flag has been high for SHORT_CYCLES consecutive cycles of running. The state changes on the following cycle, and a shorter low run has no effect.
- R11: When several faults are present together in running, the latch class wins over the recovery class, and the recovery class wins over the hiccup class. Recovery-class faults are ignored in stopped.
- R12: The reset-level flag returns the block to idle on the next cycle from every state.
- R13: Start-up current select is high only in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_off_i | input | 1 | Supply below turn-off level |
| vcc_rst_i | input | 1 | Supply below logic-reset level |
| vcc_ovp_i | input | 1 | Supply over-voltage |
| bo_i | input | 1 | Brown-out present |
| otp_i | input | 1 | Over-temperature |
| cs_short_i | input | 1 | Current-sense pin shorted |
| wod_short_i | input | 1 | Winding or output diode short |
| zcd_low_i | input | 1 | Valley pin below short threshold |
| drv_en_o | output | 1 | Power switch drive permitted |
| start_cur_o | output | 1 | Start-up current source enabled |
| state_o | output | 3 | State code |

## Verification
The assertions take for granted that the inputs are synchronous flags that change only between clock edges. They also expect the supply flags to stay plausible, so that the reset level is never reported without a later return to idle. The bench changes every input at the falling edge and samples at the next falling edge, so each transition is seen one rising edge later. The bench uses short intervals, and it holds the valley-low flag only for runs measured against SHORT_CYCLES. This keeps every timer window short enough that the counter-based checks cover the whole run.

// File: rtl/fault_pkg.sv
package fault_pkg;
  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_STOP  = 3'd1,
    ST_RUN   = 3'd2,
    ST_DISCH = 3'd3,
    ST_RECOV = 3'd4,
    ST_LATCH = 3'd5
  } fsm_state_e;
endpackage

// File: rtl/cycle_timer.sv
module cycle_timer #(
  parameter int LEN = 4,
  localparam int CNT_W = $clog2(LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  // load LEN-1 so the owning state lasts exactly LEN cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CNT_W'(LEN - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  a_r3_timer_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/short_filter.sv
module short_filter #(
  parameter int SHORT_CYCLES = 5,
  localparam int CNT_W = $clog2(SHORT_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic zcd_low_i,
  output logic short_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!(zcd_low_i && arm_i))     cnt_q <= '0;
    else if (cnt_q != CNT_W'(SHORT_CYCLES)) cnt_q <= cnt_q + 1'b1;
  end

  assign short_o = (cnt_q == CNT_W'(SHORT_CYCLES));

  a_r10_short_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o |-> $past(zcd_low_i && arm_i));
endmodule

// File: rtl/fault_fsm.sv
module fault_fsm
  import fault_pkg::*;
#(
  parameter bit LATCHED = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vcc_on_i,
  input  logic       vcc_off_i,
  input  logic       vcc_rst_i,
  input  logic       vcc_ovp_i,
  input  logic       bo_i,
  input  logic       otp_i,
  input  logic       cs_short_i,
  input  logic       wod_short_i,
  input  logic       aux_short_i,
  input  logic       ss_done_i,
  input  logic       rc_done_i,
  output logic       ss_load_o,
  output logic       rc_load_o,
  output fsm_state_e state_o
);
  fsm_state_e state_q, state_d;
  logic bo_q, bo_exit;
  logic latch_fault, recov_fault, hiccup_fault;

  generate
    if (LATCHED) begin : g_latch
      assign latch_fault = wod_short_i | aux_short_i;
    end else begin : g_auto
      assign latch_fault = 1'b0;
    end
  endgenerate

  assign recov_fault  = vcc_ovp_i | wod_short_i | aux_short_i;
  assign hiccup_fault = bo_i | otp_i | cs_short_i;
  assign bo_exit      = bo_q & ~bo_i;

  always_comb begin
    state_d = state_q;
    if (vcc_rst_i) state_d = ST_RESET;
    else begin
      case (state_q)
        ST_LATCH: state_d = ST_LATCH;
        ST_RECOV: if (rc_done_i) state_d = ST_RESET;
        default: begin
          if (vcc_off_i || bo_exit) state_d = ST_RESET;
          else begin
            case (state_q)
              ST_RESET: if (vcc_on_i) state_d = ST_STOP;
              ST_STOP: begin
                if (hiccup_fault)   state_d = ST_DISCH;
                else if (ss_done_i) state_d = ST_RUN;
              end
              ST_RUN: begin
                if (latch_fault)       state_d = ST_LATCH;
                else if (recov_fault)  state_d = ST_RECOV;
                else if (hiccup_fault) state_d = ST_DISCH;
              end
              ST_DISCH: state_d = ST_DISCH;
              default:  state_d = ST_RESET;
            endcase
          end
        end
      endcase
    end
  end

  assign ss_load_o = (state_d == ST_STOP)  && (state_q != ST_STOP);
  assign rc_load_o = (state_d == ST_RECOV) && (state_q != ST_RECOV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      bo_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bo_q    <= bo_i;
    end
  end

  assign state_o = state_q;

  a_r12_rst_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_rst_i |=> (state_q == ST_RESET));
  a_r8_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LATCH && !vcc_rst_i) |=> (state_q == ST_LATCH));
  a_r7_recov_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOV && !rc_done_i && !vcc_rst_i) |=> (state_q == ST_RECOV));
  a_r3_run_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> ($past(state_q) == ST_STOP && $past(ss_done_i)));
  a_r2_stop_needs_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && $past(state_q) == ST_RESET) |-> $past(vcc_on_i));
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fault_pkg::*;
#(
  parameter bit LATCHED          = 1'b0,
  parameter int SOFTSTART_CYCLES = 4000,
  parameter int RECOVERY_CYCLES  = 400_000_000,
  parameter int SHORT_CYCLES     = 9_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vcc_on_i,
  input  logic       vcc_off_i,
  input  logic       vcc_rst_i,
  input  logic       vcc_ovp_i,
  input  logic       bo_i,
  input  logic       otp_i,
  input  logic       cs_short_i,
  input  logic       wod_short_i,
  input  logic       zcd_low_i,
  output logic       drv_en_o,
  output logic       start_cur_o,
  output logic [2:0] state_o
);
  fsm_state_e state;
  logic ss_load, rc_load, ss_done, rc_done, aux_short;

  short_filter #(.SHORT_CYCLES(SHORT_CYCLES)) u_short (
    .clk_i, .rst_ni,
    .arm_i    (state == ST_RUN),
    .zcd_low_i,
    .short_o  (aux_short)
  );

  cycle_timer #(.LEN(SOFTSTART_CYCLES)) u_softstart (
    .clk_i, .rst_ni, .load_i(ss_load), .done_o(ss_done)
  );

  cycle_timer #(.LEN(RECOVERY_CYCLES)) u_recovery (
    .clk_i, .rst_ni, .load_i(rc_load), .done_o(rc_done)
  );

  fault_fsm #(.LATCHED(LATCHED)) u_fsm (
    .clk_i, .rst_ni,
    .vcc_on_i, .vcc_off_i, .vcc_rst_i, .vcc_ovp_i,
    .bo_i, .otp_i, .cs_short_i, .wod_short_i,
    .aux_short_i (aux_short),
    .ss_done_i   (ss_done),
    .rc_done_i   (rc_done),
    .ss_load_o   (ss_load),
    .rc_load_o   (rc_load),
    .state_o     (state)
  );

  assign drv_en_o    = (state == ST_RUN);
  assign start_cur_o = (state == ST_RESET);
  assign state_o     = state;

  a_r13_start_cur_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_cur_o) |-> (state_o == 3'd0 && !drv_en_o));
  a_r3_drive_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_en_o && start_cur_o));
endmodule

// File: tb/fault_supervisor_test.sv
module fault_supervisor_test;
  localparam int SS = 4;
  localparam int RC = 10;
  localparam int SH = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vcc_on = 0, vcc_off = 0, vcc_rst = 0, ovp = 0, bo = 0, otp = 0, cs = 0, wod = 0, zcd = 0;
  logic drv_a, start_a, drv_l, start_l;
  logic [2:0] st_a, st_l;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  fault_supervisor #(.LATCHED(1'b0), .SOFTSTART_CYCLES(SS), .RECOVERY_CYCLES(RC), .SHORT_CYCLES(SH)) uut (
    .clk_i(clk), .rst_ni, .vcc_on_i(vcc_on), .vcc_off_i(vcc_off), .vcc_rst_i(vcc_rst),
    .vcc_ovp_i(ovp), .bo_i(bo), .otp_i(otp), .cs_short_i(cs), .wod_short_i(wod), .zcd_low_i(zcd),
    .drv_en_o(drv_a), .start_cur_o(start_a), .state_o(st_a));

  fault_supervisor #(.LATCHED(1'b1), .SOFTSTART_CYCLES(SS), .RECOVERY_CYCLES(RC), .SHORT_CYCLES(SH)) uut_latch (
    .clk_i(clk), .rst_ni, .vcc_on_i(vcc_on), .vcc_off_i(vcc_off), .vcc_rst_i(vcc_rst),
    .vcc_ovp_i(ovp), .bo_i(bo), .otp_i(otp), .cs_short_i(cs), .wod_short_i(wod), .zcd_low_i(zcd),
    .drv_en_o(drv_l), .start_cur_o(start_l), .state_o(st_l));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_faults();
    ovp = 0; bo = 0; otp = 0; cs = 0; wod = 0; zcd = 0; vcc_off = 0;
  endtask

  task automatic go_run();
    clear_faults();
    vcc_rst = 1; vcc_on = 1;
    tick();
    vcc_rst = 0;
    tick();
    repeat (SS) tick();
    check("R3 go_run auto", st_a, 2);
    check("R3 go_run latched", st_l, 2);
  endtask

  initial begin
    #(200000 * 8);
    fails++; tests++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 / R13
    check("R1 state", st_a, 0);
    check("R1 drv", drv_a, 0);
    check("R13 start_cur", start_a, 1);
    // R2
    repeat (3) tick();
    check("R2 idle without on", st_a, 0);
    vcc_on = 1;
    tick();
    check("R2 stop auto", st_a, 1);
    check("R2 stop latched", st_l, 1);
    check("R13 start_cur off", start_a, 0);
    check("R3 drv low in stop", drv_a, 0);
    // R3 soft-start length
    repeat (SS - 1) tick();
    check("R3 still stop", st_a, 1);
    tick();
    check("R3 run", st_a, 2);
    check("R3 drv high in run", drv_a, 1);
    // R4
    vcc_off = 1;
    tick();
    check("R4 turn-off to idle", st_a, 0);
    vcc_off = 0;

    // sweep of single faults: 0 ovp, 1 bo, 2 otp, 3 cs, 4 wod
    for (int k = 0; k < 5; k++) begin
      go_run();
      ovp = (k == 0); bo = (k == 1); otp = (k == 2); cs = (k == 3); wod = (k == 4);
      tick();
      // R5 hiccup -> 3, R7 recovery -> 4, R8 latch -> 5, R9 ovp latched -> 4
      check("R5/R7 sweep auto", st_a, (k == 0 || k == 4) ? 4 : 3);
      check("R8/R9 sweep latched", st_l, (k == 4) ? 5 : ((k == 0) ? 4 : 3));
      check("R3 drv off after fault", drv_a, 0);
    end

    // R5 discharge waits for turn-off
    go_run();
    otp = 1;
    tick();
    otp = 0;
    repeat (3) tick();
    check("R5 discharge holds", st_a, 3);
    vcc_off = 1;
    tick();
    check("R5 turn-off ends discharge", st_a, 0);
    vcc_off = 0;

    // R6 brown-out exit
    go_run();
    bo = 1;
    tick();
    tick();
    check("R6 discharge during brown-out", st_a, 3);
    bo = 0;
    tick();
    check("R6 brown-out exit to idle", st_a, 0);
    check("R6 brown-out exit latched", st_l, 0);

    // R7 recovery length, turn-off ignored
    go_run();
    ovp = 1;
    tick();
    check("R7 recovery entry", st_a, 4);
    ovp = 0; vcc_off = 1;
    repeat (RC - 1) tick();
    check("R7 recovery holds", st_a, 4);
    check("R9 latched recovery holds", st_l, 4);
    tick();
    check("R7 recovery ends", st_a, 0);
    vcc_off = 0;

    // R8 latch holds
    go_run();
    wod = 1;
    tick();
    check("R8 auto recovers", st_a, 4);
    check("R8 latched", st_l, 5);
    wod = 0; vcc_off = 1; bo = 1;
    tick();
    bo = 0; otp = 1;
    tick();
    otp = 0;
    repeat (RC + 2) tick();
    check("R8 latch ignores", st_l, 5);
    check("R8 latch drv", drv_l, 0);
    check("R13 latch start_cur", start_l, 0);
    check("R7 auto back to idle", st_a, 0);
    vcc_off = 0; vcc_rst = 1;
    tick();
    check("R8 release", st_l, 0);
    check("R12 idle auto", st_a, 0);
    vcc_rst = 0;

    // R10 short filter
    go_run();
    zcd = 1;
    repeat (SH - 1) tick();
    zcd = 0;
    repeat (3) tick();
    check("R10 short run too brief", st_a, 2);
    zcd = 1;
    repeat (SH) tick();
    check("R10 not yet", st_a, 2);
    tick();
    check("R10 aux short auto", st_a, 4);
    check("R10 aux short latched", st_l, 5);
    zcd = 0;

    // R11 priority
    go_run();
    wod = 1; ovp = 1; otp = 1; cs = 1;
    tick();
    check("R11 latch wins", st_l, 5);
    check("R11 recovery wins auto", st_a, 4);
    go_run();
    ovp = 1; otp = 1;
    tick();
    check("R11 recovery over hiccup", st_a, 4);
    clear_faults();
    vcc_rst = 1;
    tick();
    vcc_rst = 0;
    tick();
    check("R11 stop", st_a, 1);
    ovp = 1;
    tick();
    check("R11 ovp ignored in stop", st_a, 1);
    ovp = 0;

    // R12 from run
    go_run();
    vcc_rst = 1;
    tick();
    check("R12 reset level from run", st_a, 0);
    check("R12 reset level latched", st_l, 0);
    vcc_rst = 0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule